// File: doc/BRIEF.md
# Atomic-Launch Message Network Interface

This block sits between a processor's register bus and a flit-based network port. To send, software writes a header word and up to seven payload words into a small send register file. These writes never reach the network. A single launch command copies the whole message into a transmit snapshot and streams it out as valid/ready flits, with the last flit marked as the tail. Because nothing leaves before the launch, a message that is only partly written can be read back, saved, abandoned or restored across a context switch.

On the receive side, arriving flits fill a queue of up to four whole messages. The message at the head of the queue is visible in place through a read window. Software reads it there and then writes a dispose command, which frees it and moves the next message to the head. A user message at the head is announced by a pollable status bit and, unless masked, by a user interrupt. A message whose header carries the system flag is not shown in the user window. It raises a separate system interrupt and is readable only through a system window.

Top module: `msgNetIf`

## Requirements
- R1: After reset, txValid, irqUser and irqSys are low, rxReady is high, the status register (0x11) reads 0 and the mask register (0x12) reads 1, so user interrupts start out masked.
- R2: Writes to the send registers (0x00..0x07) never cause a flit to be sent, and each send register reads back the last value written to it.
- R3: A launch is a write to 0x10 with bit 0 set. It sends words 0..L-1 of the send registers in order, where L is bits [3:0] of word 0, with txTail high on the last flit only.
- R4: Once launched, a message is unaffected by later writes to the send registers. While txValid is high and txReady is low, txData and txTail hold their values.
- R5: A launch is refused, with no flit sent, when a message is still draining or when L is 0 or above 8. A refusal sets the sticky error bit (status bit 2), which a write to 0x10 with bit 2 set clears.
- R6: A received user message at the head is readable at 0x08+i (word i), and status bit 0 is set. Status bits [6:4] give the number of whole messages queued.
- R7: irqUser is high exactly when a user message is at the head and mask bit 0 is clear. With the mask set, only status bit 0 shows the arrival.
- R8: A message whose header has bit 4 set is a system message. At the head it drives irqSys high, keeps irqUser and status bit 0 low, sets status bit 3, reads as 0 in the user window and is readable at 0x18+i.
- R9: A write to 0x10 with bit 1 set disposes of the head message and exposes the next one in arrival order. A dispose with the queue empty has no effect.
- R10: With four messages queued, rxReady is low. It returns high once a message is disposed of.
- R11: Register 0x13 returns the number of words received for the head message, and 0 when the queue is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | 5 | Register address |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data (combinational from regAddr) |
| txValid | output | 1 | Outgoing flit valid |
| txReady | input | 1 | Network accepts outgoing flit |
| txData | output | 32 | Outgoing flit payload |
| txTail | output | 1 | Outgoing flit is the last of its message |
| rxValid | input | 1 | Incoming flit valid |
| rxReady | output | 1 | Interface accepts incoming flit |
| rxData | input | 32 | Incoming flit payload |
| rxTail | input | 1 | Incoming flit is the last of its message |
| irqUser | output | 1 | User message waiting and not masked |
| irqSys | output | 1 | System message waiting |

## Verification
The hardest case to reach is a launch command that arrives while a message is still draining, combined with rewrites of the send registers during that drain. The stimulus holds txReady low on two cycles out of three while an eight-word message is in flight. It then overwrites a send word and issues a second launch inside that window. The scoreboard expects only the original eight flits. Filling the receive queue to exactly four messages, so that back-pressure can be seen, is done by delivering four tagged messages with no dispose in between.

// File: rtl/niPkg.sv
package niPkg;
  localparam int DATA_W    = 32;
  localparam int MAX_WORDS = 8;
  localparam int RX_DEPTH  = 4;
  localparam int ADDR_W    = 5;
  localparam int IDX_W     = $clog2(MAX_WORDS);
  localparam int SLOT_W    = $clog2(RX_DEPTH);
  localparam int CNT_W     = $clog2(RX_DEPTH + 1);
  localparam int LEN_W     = 4;
  localparam int SYS_BIT   = 4;

  localparam logic [ADDR_W-1:0] ADDR_CMD    = 5'h10;
  localparam logic [ADDR_W-1:0] ADDR_STATUS = 5'h11;
  localparam logic [ADDR_W-1:0] ADDR_MASK   = 5'h12;
  localparam logic [ADDR_W-1:0] ADDR_HLEN   = 5'h13;
  localparam logic [1:0]        BANK_SEND   = 2'b00;
  localparam logic [1:0]        BANK_UWIN   = 2'b01;
  localparam logic [1:0]        BANK_SWIN   = 2'b11;

  typedef struct packed {
    logic              sendWr;
    logic [IDX_W-1:0]  sendIdx;
    logic              snapLoad;
    logic [IDX_W-1:0]  txIdx;
    logic              rxWr;
    logic [SLOT_W-1:0] rxSlot;
    logic [IDX_W-1:0]  rxIdx;
    logic [SLOT_W-1:0] headSlot;
  } niStrobe_t;

  typedef struct packed {
    logic             txBusy;
    logic             launchErr;
    logic [CNT_W-1:0] rxCount;
    logic             headValid;
    logic             headSys;
    logic [IDX_W:0]   headLen;
    logic             rxMask;
  } niStatus_t;
endpackage

// File: rtl/niControl.sv
module niControl
  import niPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [2:0]        cmdBits,
  input  logic              maskBit,
  input  logic [LEN_W-1:0]  sendLen,
  input  logic              txReady,
  input  logic              rxValid,
  input  logic              rxTail,
  input  logic              rxSysBit,
  output niStrobe_t         strobe,
  output niStatus_t         stat,
  output logic              txValid,
  output logic              txTail,
  output logic              rxReady
);
  logic cmdWr, launchReq, disposeReq, clrErr, lenOk, launchGo;
  logic txBusy, launchErr, rxMask;
  logic [IDX_W-1:0] txIdx, lastIdx;
  logic [SLOT_W-1:0] wrSlot, rdSlot;
  logic [IDX_W-1:0] wrIdx;
  logic [CNT_W-1:0] count;
  logic slotSys [RX_DEPTH];
  logic [IDX_W:0] slotLen [RX_DEPTH];
  logic accept, commit, pop;

  assign cmdWr      = regWrEn && (regAddr == ADDR_CMD);
  assign launchReq  = cmdWr && cmdBits[0];
  assign disposeReq = cmdWr && cmdBits[1];
  assign clrErr     = cmdWr && cmdBits[2];
  assign lenOk      = (sendLen != '0) && (sendLen <= LEN_W'(MAX_WORDS));
  assign launchGo   = launchReq && !txBusy && lenOk;

  // transmit sequencer
  always_ff @(posedge clk) begin
    if (!rstN) begin
      txBusy  <= 1'b0;
      txIdx   <= '0;
      lastIdx <= '0;
    end else if (launchGo) begin
      txBusy  <= 1'b1;
      txIdx   <= '0;
      lastIdx <= IDX_W'(sendLen - 1'b1);
    end else if (txBusy && txReady) begin
      if (txIdx == lastIdx) txBusy <= 1'b0;
      else                  txIdx  <= txIdx + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                       launchErr <= 1'b0;
    else if (launchReq && !launchGo) launchErr <= 1'b1;
    else if (clrErr)                 launchErr <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                                    rxMask <= 1'b1;
    else if (regWrEn && regAddr == ADDR_MASK)     rxMask <= maskBit;
  end

  assign txValid = txBusy;
  assign txTail  = txBusy && (txIdx == lastIdx);

  // receive queue bookkeeping
  assign rxReady = (count != CNT_W'(RX_DEPTH));
  assign accept  = rxValid && rxReady;
  assign commit  = accept && rxTail;
  assign pop     = disposeReq && (count != '0);

  function automatic logic [SLOT_W-1:0] nextSlot(input logic [SLOT_W-1:0] s);
    return (s == SLOT_W'(RX_DEPTH - 1)) ? '0 : s + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrSlot <= '0;
      rdSlot <= '0;
      wrIdx  <= '0;
      count  <= '0;
    end else begin
      if (accept) begin
        if (rxTail) begin
          wrIdx  <= '0;
          wrSlot <= nextSlot(wrSlot);
        end else if (wrIdx != IDX_W'(MAX_WORDS - 1)) begin
          wrIdx <= wrIdx + 1'b1;
        end
      end
      if (pop) rdSlot <= nextSlot(rdSlot);
      count <= count + CNT_W'(commit) - CNT_W'(pop);
    end
  end

  generate
    for (genvar s = 0; s < RX_DEPTH; s++) begin : g_slot
      always_ff @(posedge clk) begin
        if (!rstN) begin
          slotSys[s] <= 1'b0;
          slotLen[s] <= '0;
        end else if (accept && wrSlot == SLOT_W'(s)) begin
          if (wrIdx == '0) slotSys[s] <= rxSysBit;
          if (rxTail)      slotLen[s] <= {1'b0, wrIdx} + 1'b1;
        end
      end
    end
  endgenerate

  always_comb begin
    strobe.sendWr   = regWrEn && (regAddr[ADDR_W-1 -: 2] == BANK_SEND);
    strobe.sendIdx  = regAddr[IDX_W-1:0];
    strobe.snapLoad = launchGo;
    strobe.txIdx    = txIdx;
    strobe.rxWr     = accept;
    strobe.rxSlot   = wrSlot;
    strobe.rxIdx    = wrIdx;
    strobe.headSlot = rdSlot;
  end

  always_comb begin
    stat.txBusy    = txBusy;
    stat.launchErr = launchErr;
    stat.rxCount   = count;
    stat.headValid = (count != '0);
    stat.headSys   = slotSys[rdSlot];
    stat.headLen   = (count != '0) ? slotLen[rdSlot] : '0;
    stat.rxMask    = rxMask;
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    count <= CNT_W'(RX_DEPTH)); // R10
  AST_FULL_STALLS: assert property (@(posedge clk) disable iff (!rstN)
    (count == CNT_W'(RX_DEPTH) && !pop) |=> !accept || !rxValid || $past(pop)); // R10
  AST_BUSY_REFUSED: assert property (@(posedge clk) disable iff (!rstN)
    (launchReq && txBusy) |=> launchErr); // R5
  AST_TAIL_ENDS: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && txReady && txTail) |=> !txValid); // R3
endmodule

// File: rtl/niDatapath.sv
module niDatapath
  import niPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  niStrobe_t         strobe,
  input  niStatus_t         stat,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  input  logic [DATA_W-1:0] rxData,
  output logic [DATA_W-1:0] regRdData,
  output logic [DATA_W-1:0] txData,
  output logic [LEN_W-1:0]  sendLen
);
  logic [DATA_W-1:0] sendRegs [MAX_WORDS];
  logic [DATA_W-1:0] snapRegs [MAX_WORDS];
  logic [DATA_W-1:0] rxMem    [RX_DEPTH][MAX_WORDS];
  logic [DATA_W-1:0] headWord;
  logic userHead, sysHead;

  generate
    for (genvar w = 0; w < MAX_WORDS; w++) begin : g_word
      always_ff @(posedge clk) begin
        if (!rstN)                                          sendRegs[w] <= '0;
        else if (strobe.sendWr && strobe.sendIdx == IDX_W'(w)) sendRegs[w] <= regWrData;
      end
      // launch copies the composed message so later edits cannot disturb it
      always_ff @(posedge clk) begin
        if (!rstN)                snapRegs[w] <= '0;
        else if (strobe.snapLoad) snapRegs[w] <= sendRegs[w];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (strobe.rxWr) rxMem[strobe.rxSlot][strobe.rxIdx] <= rxData;
  end

  assign txData   = snapRegs[strobe.txIdx];
  assign sendLen  = sendRegs[0][LEN_W-1:0];
  assign headWord = rxMem[strobe.headSlot][regAddr[IDX_W-1:0]];
  assign userHead = stat.headValid && !stat.headSys;
  assign sysHead  = stat.headValid && stat.headSys;

  always_comb begin
    regRdData = '0;
    unique case (regAddr[ADDR_W-1 -: 2])
      BANK_SEND: regRdData = sendRegs[regAddr[IDX_W-1:0]];
      BANK_UWIN: regRdData = userHead ? headWord : '0;
      BANK_SWIN: regRdData = sysHead  ? headWord : '0;
      default: begin
        if (regAddr == ADDR_STATUS)
          regRdData = DATA_W'({stat.rxCount, sysHead, stat.launchErr,
                               stat.txBusy, userHead});
        else if (regAddr == ADDR_MASK)
          regRdData = DATA_W'(stat.rxMask);
        else if (regAddr == ADDR_HLEN)
          regRdData = DATA_W'(stat.headLen);
      end
    endcase
  end

  AST_SNAP_ONLY_ON_LAUNCH: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.snapLoad && stat.txBusy) |=> $stable(snapRegs[0])); // R4
endmodule

// File: rtl/msgNetIf.sv
module msgNetIf
  import niPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  output logic              txValid,
  input  logic              txReady,
  output logic [DATA_W-1:0] txData,
  output logic              txTail,
  input  logic              rxValid,
  output logic              rxReady,
  input  logic [DATA_W-1:0] rxData,
  input  logic              rxTail,
  output logic              irqUser,
  output logic              irqSys
);
  niStrobe_t strobe;
  niStatus_t stat;
  logic [LEN_W-1:0] sendLen;

  niControl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .regAddr  (regAddr),
    .regWrEn  (regWrEn),
    .cmdBits  (regWrData[2:0]),
    .maskBit  (regWrData[0]),
    .sendLen  (sendLen),
    .txReady  (txReady),
    .rxValid  (rxValid),
    .rxTail   (rxTail),
    .rxSysBit (rxData[SYS_BIT]),
    .strobe   (strobe),
    .stat     (stat),
    .txValid  (txValid),
    .txTail   (txTail),
    .rxReady  (rxReady)
  );

  niDatapath u_data (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .stat      (stat),
    .regAddr   (regAddr),
    .regWrData (regWrData),
    .rxData    (rxData),
    .regRdData (regRdData),
    .txData    (txData),
    .sendLen   (sendLen)
  );

  assign irqUser = stat.headValid && !stat.headSys && !stat.rxMask;
  assign irqSys  = stat.headValid && stat.headSys;

  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && !txReady) |=> txValid && $stable(txData) && $stable(txTail)); // R4
  AST_IRQ_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(irqUser && irqSys)); // R8
  AST_MASK_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == ADDR_MASK && regWrData[0]) |=> !irqUser); // R7
endmodule

// File: tb/msgNetIf_bench.sv
module msgNetIf_bench;
  localparam int CLK_PERIOD = 10;
  localparam int Q = CLK_PERIOD / 4;

  logic clk = 0, rstN = 0;
  logic [4:0] regAddr = 0;
  logic regWrEn = 0;
  logic [31:0] regWrData = 0, regRdData, txData, rxData = 0;
  logic txValid, txReady = 1, txTail, rxValid = 0, rxReady, rxTail = 0;
  logic irqUser, irqSys;

  int checks = 0, errors = 0, cyc = 0;
  bit stallMode = 0;
  logic [32:0] expQ [$];
  logic [31:0] model [8];

  always #(CLK_PERIOD/2) clk = ~clk;

  msgNetIf u_msgNetIf (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); regAddr = a; regWrData = d; regWrEn = 1;
    @(negedge clk); regWrEn = 0;
  endtask

  task automatic regRead(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk); regAddr = a; #(Q); d = regRdData;
  endtask

  task automatic launchExpect();
    int len = int'(model[0][3:0]);
    @(negedge clk); regAddr = 5'h10; regWrData = 1; regWrEn = 1;
    for (int i = 0; i < len; i++) expQ.push_back({(i == len - 1), model[i]});
    @(negedge clk); regWrEn = 0;
  endtask

  task automatic rxFlit(input logic [31:0] d, input bit tl);
    @(negedge clk); rxValid = 1; rxData = d; rxTail = tl; #(Q);
    while (!rxReady) begin @(negedge clk); #(Q); end
    @(posedge clk);
    @(negedge clk); rxValid = 0; rxTail = 0;
  endtask

  task automatic rxMsg(input logic [31:0] hdr, input logic [31:0] tag, input int len);
    for (int i = 0; i < len; i++) rxFlit(i == 0 ? hdr : tag + i, i == len - 1);
  endtask

  task automatic waitDrain();
    for (int i = 0; i < 200 && (txValid || expQ.size() != 0); i++) @(negedge clk);
  endtask

  // txReady pattern driver
  initial forever begin
    @(negedge clk); cyc++;
    txReady = stallMode ? (cyc % 3 == 0) : 1'b1;
  end

  // scoreboard monitor
  initial forever begin
    @(negedge clk); #(Q);
    if (rstN && txValid && txReady) begin
      logic [32:0] e;
      if (expQ.size() == 0) chk(0, "R2/R5 unexpected flit", txData, 0);
      else begin
        e = expQ.pop_front();
        chk(txData == e[31:0], "R3/R4 flit data", txData, e[31:0]);
        chk(txTail == e[32], "R3 tail marker", {31'd0, txTail}, {31'd0, e[32]});
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rstN = 1;
    // R1 reset state
    #(Q);
    chk(!txValid && !irqUser && !irqSys, "R1 outputs", {txValid, irqUser, irqSys}, 0);
    chk(rxReady, "R1 rxReady", rxReady, 1);
    regRead(5'h11, r); chk(r == 0, "R1 status", r, 0);
    regRead(5'h12, r); chk(r == 1, "R1 mask", r, 1);

    // R2 compose without effect, read back
    for (int i = 0; i < 8; i++) begin
      model[i] = (i == 0) ? 32'h0000_0303 : 32'hA000_0000 + i;
      regWrite(5'(i), model[i]);
    end
    for (int i = 0; i < 8; i++) begin
      regRead(5'(i), r); chk(r == model[i], "R2 readback", r, model[i]);
    end
    chk(!txValid, "R2 no flit before launch", txValid, 0);

    // R3 launch 3 words
    launchExpect();
    waitDrain();
    chk(expQ.size() == 0, "R3 all flits sent", expQ.size(), 0);

    // R4/R5 8-word message under stall, edit and relaunch while busy
    model[0] = 32'h0000_0508; regWrite(5'h0, model[0]);
    stallMode = 1;
    launchExpect();
    regWrite(5'h1, 32'hDEAD_BEEF);
    regWrite(5'h10, 32'h1);
    model[1] = 32'hDEAD_BEEF;
    waitDrain();
    stallMode = 0;
    chk(expQ.size() == 0, "R4 snapshot drained", expQ.size(), 0);
    regRead(5'h11, r); chk(r[2] == 1, "R5 sticky error", r[2], 1);
    regWrite(5'h10, 32'h4);
    regRead(5'h11, r); chk(r[2] == 0, "R5 error cleared", r[2], 0);
    model[0] = 32'h0000_0500; regWrite(5'h0, model[0]);
    regWrite(5'h10, 32'h1);
    repeat (4) @(negedge clk);
    chk(!txValid, "R5 zero length refused", txValid, 0);
    regRead(5'h11, r); chk(r[2] == 1, "R5 error on bad length", r[2], 1);
    regWrite(5'h10, 32'h4);

    // R6/R7/R11 user receive
    rxMsg(32'h0000_2103, 32'h1100_0000, 3);
    regRead(5'h11, r);
    chk(r[0] == 1 && r[6:4] == 1, "R6 status user ready, count 1", r, 32'h11);
    regRead(5'h09, r); chk(r == 32'h1100_0001, "R6 window word1", r, 32'h1100_0001);
    regRead(5'h13, r); chk(r == 3, "R11 head length", r, 3);
    chk(!irqUser, "R7 masked irq", irqUser, 0);
    regWrite(5'h12, 32'h0);
    #(Q); chk(irqUser, "R7 unmasked irq", irqUser, 1);
    regWrite(5'h10, 32'h2);

    // R8 system message
    rxMsg(32'h0000_0013, 32'h5500_0000, 3);
    #(Q);
    chk(irqSys && !irqUser, "R8 irq routing", {irqSys, irqUser}, 2);
    regRead(5'h11, r); chk(r[0] == 0 && r[3] == 1, "R8 status", r[3:0], 4'h8);
    regRead(5'h0A, r); chk(r == 0, "R8 user window hidden", r, 0);
    regRead(5'h1A, r); chk(r == 32'h5500_0002, "R8 system window", r, 32'h5500_0002);
    regWrite(5'h10, 32'h2);

    // R9 dispose empty
    regWrite(5'h10, 32'h2);
    regRead(5'h11, r); chk(r[6:4] == 0, "R9 empty dispose ignored", r[6:4], 0);
    regRead(5'h13, r); chk(r == 0, "R11 empty length", r, 0);
    chk(!irqSys && !irqUser, "R9 no irq when empty", {irqSys, irqUser}, 0);

    // R10 fill queue, R9 ordering
    for (int m = 0; m < 4; m++) rxMsg(32'h0000_0002, 32'h7000_0000 + (m << 8), 2);
    #(Q); chk(!rxReady, "R10 full back-pressure", rxReady, 0);
    regRead(5'h11, r); chk(r[6:4] == 4, "R10 count 4", r[6:4], 4);
    regRead(5'h09, r); chk(r == 32'h7000_0001, "R9 head first", r, 32'h7000_0001);
    regWrite(5'h10, 32'h2);
    #(Q); chk(rxReady, "R10 ready after dispose", rxReady, 1);
    regRead(5'h09, r); chk(r == 32'h7000_0101, "R9 next in order", r, 32'h7000_0101);

    waitDrain();
    chk(expQ.size() == 0, "R3 scoreboard empty", expQ.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule